// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a parameterised set of level-sensitive peripheral interrupt lines (32, 64 or 128) and drives one interrupt level toward each CPU. Every CPU owns a private register window made of 32-bit enable words followed by 32-bit status words, one of each per group of 32 lines. A line reaches a CPU only when the enable bit for that line in that CPU's window is set. Routing a peripheral to a particular CPU therefore means enabling it in that window alone.

The block keeps no record of events. A status bit is the live input ANDed with the enable bit. Each CPU output is the OR of that CPU's status bits and follows the inputs combinationally. There is no priority encoder, no pending queue, no polarity or edge option and no atomic set or clear. Software updates an enable word by read-modify-write and finds pending sources by scanning every status word of its window.

Top module: `l1irq_aggr`

## Requirements
- R1: While reset is high, and after it falls, every enable bit is 0. Every CPU output stays low whatever the inputs do, and every enable word reads 0.
- R2: A write to an enable word stores the written value in that CPU's enable bits for the 32 lines of that group. A later read of the same address returns that value.
- R3: A read of status word k of a CPU returns the raw inputs for lines 32k..32k+31 ANDed with that CPU's enable word k.
- R4: Output bit c is high exactly when at least one line is asserted and enabled in CPU c's window. It follows input changes in the same cycle, with no register on the path.
- R5: Enable bits of one CPU have no effect on the output or the reads of any other CPU.
- R6: A write to a status word changes no enable bit and no read value.
- R7: Byte address map: each CPU window spans 8*G bytes, where G = lines/32. CPU c starts at c*8*G. Enable word k sits at window offset 4k, and status word k sits at offset 4*(G+k). Bit b of word k is line 32k+b. Address bits 1:0 are ignored.
- R8: A read of an address at or beyond NUM_CPUS*8*G bytes returns 0. A write there changes no enable bit.
- R9: Read data appears on bus_rdata in the clock cycle after the one in which bus_rd is high. It holds that value until the next read.
- R10: An output drops in the same cycle in which its last enabled asserted input drops. It also drops in the cycle after a write clears the enable of that input.
- R11: An enable write replaces the whole word. Bits written as 0 are cleared even if they were set before, because no bit-set or bit-clear addresses exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | NUM_LINES | Raw level interrupt inputs |
| cpu_irq | output | NUM_CPUS | One interrupt level per CPU |

## Verification
The hardest case to reach from the ports is the one that proves the CPU windows are isolated. A line must be asserted while it is enabled in one CPU and absent from the other, and the bench must show that only one output rises and only one status word reports it. The stimulus enables the top line of the upper group in the second CPU only, then raises that line. It then rewrites the first CPU's enable word to a different pattern and disables the line in the owning CPU while the input stays high. This shows that the output drops with the enable change and not with the input. Writes aimed at status words and at addresses past the last window follow, each followed by read-back of every enable word.

// File: rtl/l1irq_pkg.sv
package l1irq_pkg;

    localparam int WORD_W = 32;

    // Kind of register targeted by a bus address.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_ENABLE = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;

    // Decoded bus request: which CPU window, which 32-line group, which kind.
    typedef struct packed {
        acc_kind_e   kind;
        logic [7:0]  cpu;
        logic [7:0]  grp;
    } acc_req_t;

    function automatic bit lines_legal(int n);
        return (n == 32) || (n == 64) || (n == 128);
    endfunction

    function automatic int groups_of(int n);
        return n / WORD_W;
    endfunction

    function automatic int bits_for(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/l1irq_addr_dec.sv
module l1irq_addr_dec
    import l1irq_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_req_t          req
);
    localparam int GROUPS    = groups_of(NUM_LINES);
    localparam int WIDX_BITS = $clog2(2 * GROUPS);
    localparam int CPU_BITS  = bits_for(NUM_CPUS);
    localparam int USED_BITS = 2 + WIDX_BITS + CPU_BITS;

    logic [WIDX_BITS-1:0] widx;
    logic [CPU_BITS-1:0]  cidx;
    logic                 upper_zero;
    logic                 unused_lsb;

    assign unused_lsb = ^addr[1:0];
    assign widx       = addr[2 +: WIDX_BITS];
    assign cidx       = addr[2 + WIDX_BITS +: CPU_BITS];

    generate
        if (ADDR_W > USED_BITS) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:USED_BITS] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        req.kind = ACC_NONE;
        req.cpu  = 8'(cidx);
        req.grp  = 8'd0;
        if (upper_zero && (int'(cidx) < NUM_CPUS)) begin
            if (int'(widx) < GROUPS) begin
                req.kind = ACC_ENABLE;
                req.grp  = 8'(widx);
            end else begin
                req.kind = ACC_STATUS;
                req.grp  = 8'(int'(widx) - GROUPS);
            end
        end
    end

endmodule

// File: rtl/l1irq_cpu_bank.sv
module l1irq_cpu_bank
    import l1irq_pkg::*;
#(
    parameter int NUM_LINES = 128
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [bits_for(NUM_LINES/32)-1:0] wr_grp,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic [NUM_LINES-1:0]            irq_lines,
    output logic [NUM_LINES-1:0]            en_q,
    output logic [NUM_LINES-1:0]            status,
    output logic                            irq_out
);
    localparam int GROUPS = groups_of(NUM_LINES);

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q[g*WORD_W +: WORD_W] <= '0;
                end else if (wr_en && (int'(wr_grp) == g)) begin
                    en_q[g*WORD_W +: WORD_W] <= wr_data;
                end
            end
        end
    endgenerate

    assign status  = irq_lines & en_q;
    assign irq_out = |status;

endmodule

// File: rtl/l1irq_rd_mux.sv
module l1irq_rd_mux
    import l1irq_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int NUM_CPUS  = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  acc_req_t                        req,
    input  logic [NUM_CPUS*NUM_LINES-1:0]   en_all,
    input  logic [NUM_CPUS*NUM_LINES-1:0]   st_all,
    output logic [WORD_W-1:0]               rdata
);
    localparam int GROUPS = groups_of(NUM_LINES);

    logic [WORD_W-1:0] sel_en;
    logic [WORD_W-1:0] sel_st;
    logic [WORD_W-1:0] rd_next;

    always_comb begin
        sel_en = '0;
        sel_st = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int g = 0; g < GROUPS; g++) begin
                if ((req.cpu == 8'(c)) && (req.grp == 8'(g))) begin
                    sel_en = en_all[c*NUM_LINES + g*WORD_W +: WORD_W];
                    sel_st = st_all[c*NUM_LINES + g*WORD_W +: WORD_W];
                end
            end
        end
        case (req.kind)
            ACC_ENABLE: rd_next = sel_en;
            ACC_STATUS: rd_next = sel_st;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/l1irq_aggr.sv
module l1irq_aggr
    import l1irq_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic [NUM_CPUS-1:0]  cpu_irq
);
    localparam int GROUPS = groups_of(NUM_LINES);
    localparam int GRP_W  = bits_for(GROUPS);

    generate
        if (!lines_legal(NUM_LINES)) begin : g_bad_lines
            $error("l1irq_aggr: NUM_LINES must be 32, 64 or 128");
        end
    endgenerate

    acc_req_t                        req;
    logic [NUM_CPUS*NUM_LINES-1:0]   en_all;
    logic [NUM_CPUS*NUM_LINES-1:0]   st_all;

    l1irq_addr_dec #(
        .NUM_LINES (NUM_LINES),
        .NUM_CPUS  (NUM_CPUS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .req  (req)
    );

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            logic wr_here;
            assign wr_here = bus_wr && (req.kind == ACC_ENABLE) && (req.cpu == 8'(c));

            l1irq_cpu_bank #(
                .NUM_LINES (NUM_LINES)
            ) u_bank (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (wr_here),
                .wr_grp    (req.grp[GRP_W-1:0]),
                .wr_data   (bus_wdata),
                .irq_lines (irq_lines),
                .en_q      (en_all[c*NUM_LINES +: NUM_LINES]),
                .status    (st_all[c*NUM_LINES +: NUM_LINES]),
                .irq_out   (cpu_irq[c])
            );
        end
    endgenerate

    l1irq_rd_mux #(
        .NUM_LINES (NUM_LINES),
        .NUM_CPUS  (NUM_CPUS)
    ) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (bus_rd),
        .req    (req),
        .en_all (en_all),
        .st_all (st_all),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/l1irq_aggr_chk.sv
module l1irq_aggr_chk #(
    parameter int NUM_LINES = 128,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 12
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_wr,
    input logic                          bus_rd,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic [31:0]                   bus_rdata,
    input logic [NUM_LINES-1:0]          irq_lines,
    input logic [NUM_CPUS-1:0]           cpu_irq,
    input logic [NUM_CPUS*NUM_LINES-1:0] en_all
);
    localparam int GROUPS = NUM_LINES / 32;
    localparam int WIN    = 8 * GROUPS;

    logic in_range;
    logic to_status;
    int   wr_base;

    always_comb begin
        in_range  = int'(bus_addr) < NUM_CPUS * WIN;
        to_status = ((int'(bus_addr) >> 2) % (2 * GROUPS)) >= GROUPS;
        wr_base   = ((int'(bus_addr) >> 2) / (2 * GROUPS)) * NUM_LINES
                  + ((int'(bus_addr) >> 2) % (2 * GROUPS)) * 32;
        if (!in_range || to_status) wr_base = 0;
    end

    // R1: enables are clear on the first cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk) $fell(rst) |-> (en_all == '0));

    // R2: an enable write lands in the addressed word
    p_en_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_range && !to_status) |=> (en_all[$past(wr_base) +: 32] == $past(bus_wdata)));

    // R2: enables never move without a write
    p_idle_keeps_en_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(en_all));

    // R6: status writes are ignored
    p_status_wr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && in_range && to_status) |=> $stable(en_all));

    // R8: out-of-range writes are ignored, reads return zero
    p_oob_wr_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !in_range) |=> $stable(en_all));
    p_oob_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !in_range) |=> (bus_rdata == 32'd0));

    // R10: with no input asserted, no CPU is interrupted
    p_no_src_no_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_lines == '0) |-> (cpu_irq == '0));

    // R4 / R5: each output tracks only its own enabled inputs
    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_out
            p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
                cpu_irq[c] |-> ((irq_lines & en_all[c*NUM_LINES +: NUM_LINES]) != '0));
            p_enabled_raises_r5: assert property (@(posedge clk) disable iff (rst)
                ((irq_lines & en_all[c*NUM_LINES +: NUM_LINES]) != '0) |-> cpu_irq[c]);
        end
    endgenerate

endmodule

bind l1irq_aggr l1irq_aggr_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPUS  (NUM_CPUS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .cpu_irq   (cpu_irq),
    .en_all    (en_all)
);

// File: tb/l1irq_aggr_tb.sv
`timescale 1ns/1ps
module l1irq_aggr_tb;
    localparam int LINES = 64;
    localparam int CPUS  = 2;
    localparam int AW    = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [LINES-1:0] irq_lines = '0;
    logic [CPUS-1:0]  cpu_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [LINES-1:0] m_en [CPUS];
    logic [31:0]      exp_q [$];
    string            tag_q [$];
    logic             rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    l1irq_aggr #(.NUM_LINES(LINES), .NUM_CPUS(CPUS), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .cpu_irq(cpu_irq)
    );

    // Window of 16 bytes per CPU: words 0,1 enable, words 2,3 status.
    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        int c;
        int w;
        if (a >= 8'd32) return 32'd0;
        c = int'(a[4]);
        w = int'(a[3:2]);
        if (w < 2) return m_en[c][w*32 +: 32];
        return m_en[c][(w-2)*32 +: 32] & irq_lines[(w-2)*32 +: 32];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag);
        logic [CPUS-1:0] e;
        for (int c = 0; c < CPUS; c++) e[c] = |(irq_lines & m_en[c]);
        check(tag, 32'(cpu_irq), 32'(e));
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a < 8'd32 && a[3:2] < 2'd2) m_en[int'(a[4])][int'(a[3:2])*32 +: 32] = d;
    endtask

    // Driver: issue a read and push the expected word for the monitor.
    task automatic rd(logic [AW-1:0] a, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_irq(logic [LINES-1:0] v, string tag);
        @(negedge clk);
        irq_lines = v;
        #1;
        check_out(tag);
    endtask

    always @(posedge clk) rd_seen <= bus_rd && !rst;

    // Monitor: R9, data valid the cycle after the strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected read data", 32'd1, 32'd0);
                end else begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < CPUS; c++) m_en[c] = '0;
        irq_lines = '1;
        repeat (3) @(negedge clk);
        check("R1 outputs low in reset", 32'(cpu_irq), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs low after reset", 32'(cpu_irq), 32'd0);
        for (int a = 0; a < 32; a += 4) rd(AW'(a), "R1 enable words zero / R3 status zero");
        irq_lines = '0;

        wr(8'h00, 32'h0000_00F0);
        rd(8'h00, "R2 enable readback");
        rd(8'h10, "R5 other cpu untouched");
        set_irq(64'h10, "R4 cpu0 raised, R5 cpu1 quiet");
        rd(8'h08, "R3 status cpu0 word0");
        rd(8'h18, "R5 status cpu1 word0 zero");
        set_irq(64'h0, "R10 drop with input");

        wr(8'h14, 32'h8000_0000);
        set_irq(64'h8000_0000_0000_0000, "R7 line 63 routes to cpu1 only");
        rd(8'h1C, "R7 status cpu1 word1 bit31");
        rd(8'h0C, "R7 status cpu0 word1 zero");
        rd(8'h15, "R7 low address bits ignored");

        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h00, "R6 enable after status write");
        rd(8'h14, "R6 enable cpu1 after status write");
        rd(8'h1C, "R6 status unchanged");

        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h20, "R8 oob read zero");
        rd(8'hFC, "R8 far oob read zero");
        for (int a = 0; a < 32; a += 4) rd(AW'(a), "R8 no enable changed by oob write");

        wr(8'h00, 32'h0000_0001);
        rd(8'h00, "R11 whole word replaced");
        set_irq(64'h8000_0000_0000_0020, "R11 old bit no longer routes");
        set_irq(64'h8000_0000_0000_0021, "R4 new bit routes");

        wr(8'h14, 32'h0);
        #1;
        check_out("R10 drop on enable clear");
        rd(8'h1C, "R3 status after disable");

        repeat (4) @(negedge clk);
        check("R9 all reads returned", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule